// File: doc/BRIEF.md
# Cascaded Indirect Effective-Address Generator

This block produces the effective operand address for a single-accumulator machine with 36-bit words. An instruction arrives as an 18-bit address field and a 6-bit tag. The tag decides which register, if any, is added to the address field. It also decides whether indexing happens before or after an indirect fetch from memory. Each indirect word carries its own address field and tag, so the walk can pass through memory any number of times, up to a configured depth. The block reads the eight index registers, the halves of the A and Q registers and the instruction counter through input ports. It fetches indirect words over a one-request, one-response read port.

A walk starts with a one-cycle `start` pulse. The block then runs on its own. It finishes with a one-cycle `done` pulse that presents one of three results: the 18-bit effective address, an immediate-operand indication, or a fault for an illegal modifier.

Top module: `ea_walker`

## Requirements
- R1: While reset is held, and directly after it is released, `busy`, `done`, `mem_req` and `fault` are all low.
- R2: Tag bits [5:4] give the mode: 00 = plain register, 01 = register then indirect, 10 = tally (unsupported), 11 = indirect then register. Tag bits [3:0] select the register: 0000 none, 0001 A upper, 0010 Q upper, 0011 immediate-upper, 0100 instruction counter, 0101 A lower, 0110 Q lower, 0111 immediate-lower, 1000–1111 index 0–7. Upper means bits [35:18] and lower means bits [17:0].
- R3: In plain-register mode with no pending saved register, the immediate-upper and immediate-lower selectors end the walk with `imm` = 1 and `ea` = address field. `imm_upper` is 1 for immediate-upper and 0 for immediate-lower. No memory read is made.
- R4: In plain-register mode, `ea` = address field + selected register, modulo 2^18, and the result has `imm` = 0. Selector none adds zero.
- R5: In register-then-indirect mode, the block reads the word at address field + selected register. It then continues with that word's bits [35:18] as the address field and bits [5:0] as the tag.
- R6: In indirect-then-register mode, the block reads the word at the address field as it stands. Only the first such selector in a walk is saved. When the walk reaches plain-register mode, the saved selector replaces the final word's selector and is added to the final address, so the result is never immediate.
- R7: Tally mode faults. The immediate selectors also fault in register-then-indirect and indirect-then-register modes. A faulted walk ends with `fault` = 1 and `imm` = 0.
- R8: A walk makes at most MAX_DEPTH memory reads (default 8). A further read that the walk needs ends it with `fault` = 1 instead.
- R9: `done` and each `mem_req` are one-cycle pulses. A walk issues no second request until the previous read has returned. A `start` that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk with `ins_y`/`ins_tag` |
| ins_y | input | 18 | Instruction address field |
| ins_tag | input | 6 | Instruction tag |
| xr | input | 144 | Index registers, register i at bits [18i+17:18i] |
| a_reg | input | 36 | A register |
| q_reg | input | 36 | Q register |
| ic | input | 18 | Instruction counter |
| mem_req | output | 1 | One-cycle indirect-word read request |
| mem_addr | output | 18 | Read address |
| mem_valid | input | 1 | Read data valid |
| mem_data | input | 36 | Indirect word: address [35:18], tag [5:0] |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle result strobe |
| ea | output | 18 | Effective address or immediate field |
| imm | output | 1 | Result is an immediate operand |
| imm_upper | output | 1 | Immediate goes to the upper half |
| fault | output | 1 | Illegal modifier or depth exceeded |

## Verification
The hardest situation to reach is the depth limit. Hitting it needs a chain of indirect words that keeps asking for more reads. Nothing at the instruction port alone can produce that. The bench memory holds a word at address 11 that indexes by X0 = 1 from a base of 10, so it points back at itself. Entering that word through either indirect mode forces a self-loop. The bench counts the read requests it serves and checks that exactly eight are made before the fault. A two-level indirect-then-register chain, and an immediate selector met after a saved register, cover the rule that the first saved register wins.

// File: rtl/ea_walker.sv
module ea_walker #(
  parameter int AW = 18,
  parameter int WW = 36,
  parameter int MAX_DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [AW-1:0]   ins_y,
  input  logic [5:0]      ins_tag,
  input  logic [8*AW-1:0] xr,
  input  logic [WW-1:0]   a_reg,
  input  logic [WW-1:0]   q_reg,
  input  logic [AW-1:0]   ic,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  input  logic            mem_valid,
  input  logic [WW-1:0]   mem_data,
  output logic            busy,
  output logic            done,
  output logic [AW-1:0]   ea,
  output logic            imm,
  output logic            imm_upper,
  output logic            fault
);
  localparam int DW = $clog2(MAX_DEPTH + 1);
  localparam int HW = WW / 2;

  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_WAIT} st_t;
  localparam logic [1:0] M_R = 2'b00, M_RI = 2'b01, M_IT = 2'b10, M_IR = 2'b11;
  localparam logic [3:0] D_DU = 4'b0011, D_DL = 4'b0111;

  st_t         st;
  logic [AW-1:0] cur_y;
  logic [5:0]    cur_tag;
  logic [3:0]    sv_des;
  logic          sv_on;
  logic [DW-1:0] depth;

  logic [1:0]    mode;
  logic [3:0]    des, use_des;
  logic [AW-1:0] rval, sum;
  logic          des_imm, at_limit;

  assign busy     = (st != S_IDLE);
  assign mode     = cur_tag[5:4];
  assign des      = cur_tag[3:0];
  assign use_des  = (sv_on && mode == M_R) ? sv_des : des;
  assign des_imm  = (des == D_DU) || (des == D_DL);
  assign at_limit = (depth == DW'(MAX_DEPTH));
  assign sum      = cur_y + rval;

  always_comb begin
    case (use_des)
      4'b0001: rval = AW'(a_reg[WW-1:HW]);
      4'b0010: rval = AW'(q_reg[WW-1:HW]);
      4'b0100: rval = ic;
      4'b0101: rval = AW'(a_reg[HW-1:0]);
      4'b0110: rval = AW'(q_reg[HW-1:0]);
      default: rval = use_des[3] ? xr[use_des[2:0]*AW +: AW] : '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cur_y     <= '0;
      cur_tag   <= '0;
      sv_des    <= '0;
      sv_on     <= 1'b0;
      depth     <= '0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      done      <= 1'b0;
      ea        <= '0;
      imm       <= 1'b0;
      imm_upper <= 1'b0;
      fault     <= 1'b0;
    end else begin
      done    <= 1'b0;
      mem_req <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          cur_y   <= ins_y;
          cur_tag <= ins_tag;
          sv_on   <= 1'b0;
          depth   <= '0;
          st      <= S_EVAL;
        end
        S_WAIT: if (mem_valid) begin
          cur_y   <= mem_data[WW-1:WW-AW];
          cur_tag <= mem_data[5:0];
          st      <= S_EVAL;
        end
        default: begin
          st        <= S_IDLE;
          done      <= 1'b1;
          ea        <= '0;
          imm       <= 1'b0;
          imm_upper <= 1'b0;
          fault     <= 1'b0;
          if (mode == M_R) begin
            if (!sv_on && des_imm) begin
              ea        <= cur_y;
              imm       <= 1'b1;
              imm_upper <= (des == D_DU);
            end else begin
              ea <= sum;
            end
          end else if (mode == M_IT || des_imm || at_limit) begin
            fault <= 1'b1;
          end else begin
            done     <= 1'b0;
            st       <= S_WAIT;
            mem_req  <= 1'b1;
            depth    <= depth + 1'b1;
            mem_addr <= (mode == M_RI) ? sum : cur_y;
            if (mode == M_IR && !sv_on) begin
              sv_on  <= 1'b1;
              sv_des <= des;
            end
          end
        end
      endcase
    end
  end
endmodule

module ea_walker_chk #(
  parameter int MAX_DEPTH = 8
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic mem_req,
  input logic mem_valid,
  input logic done,
  input logic imm,
  input logic fault
);
  localparam int CW = $clog2(MAX_DEPTH + 2);
  logic [CW-1:0] nreq;
  logic          outstanding;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nreq        <= '0;
      outstanding <= 1'b0;
    end else begin
      if (start && !busy) nreq <= '0;
      else if (mem_req)   nreq <= nreq + 1'b1;
      if (mem_req)        outstanding <= 1'b1;
      else if (mem_valid) outstanding <= 1'b0;
    end
  end

  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy && !done && !mem_req));
  assert_imm_not_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && imm) |-> !fault);
  assert_fault_clears_imm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> !imm);
  assert_depth_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (nreq < CW'(MAX_DEPTH)));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_req_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !outstanding);
  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind ea_walker ea_walker_chk #(.MAX_DEPTH(MAX_DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .mem_req(mem_req),
  .mem_valid(mem_valid), .done(done), .imm(imm), .fault(fault)
);

// File: tb/ea_walker_test.sv
module ea_walker_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [17:0] ins_y = '0;
  logic [5:0]  ins_tag = '0;
  logic [143:0] xr;
  logic [35:0] a_reg = {18'h00010, 18'h00020};
  logic [35:0] q_reg = {18'h00030, 18'h00004};
  logic [17:0] ic = 18'h00040;
  logic mem_req, mem_valid = 1'b0;
  logic [17:0] mem_addr;
  logic [35:0] mem_data = '0;
  logic busy, done, imm, imm_upper, fault;
  logic [17:0] ea;

  int checks = 0, fails = 0, fetches = 0;
  logic [35:0] mem [32];
  logic [17:0] r_ea;
  logic r_imm, r_hi, r_flt, r_done;

  always #4 clk = ~clk;

  ea_walker uut (
    .clk(clk), .rst_n(rst_n), .start(start), .ins_y(ins_y), .ins_tag(ins_tag),
    .xr(xr), .a_reg(a_reg), .q_reg(q_reg), .ic(ic), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data),
    .busy(busy), .done(done), .ea(ea), .imm(imm), .imm_upper(imm_upper), .fault(fault)
  );

  typedef struct packed {
    logic [17:0] y; logic [5:0] tag; logic [17:0] ea;
    logic imm; logic hi; logic flt; logic [3:0] nf;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{18'd5,      6'h00, 18'd5,      1'b0, 1'b0, 1'b0, 4'd0}, // R4 none
    '{18'd100,    6'h0A, 18'd103,    1'b0, 1'b0, 1'b0, 4'd0}, // R2 X2
    '{18'd1,      6'h01, 18'h00011,  1'b0, 1'b0, 1'b0, 4'd0}, // R2 A upper
    '{18'd1,      6'h05, 18'h00021,  1'b0, 1'b0, 1'b0, 4'd0}, // R2 A lower
    '{18'd0,      6'h02, 18'h00030,  1'b0, 1'b0, 1'b0, 4'd0}, // R2 Q upper
    '{18'd2,      6'h06, 18'd6,      1'b0, 1'b0, 1'b0, 4'd0}, // R2 Q lower
    '{18'd3,      6'h04, 18'h00043,  1'b0, 1'b0, 1'b0, 4'd0}, // R2 IC
    '{18'h01234,  6'h03, 18'h01234,  1'b1, 1'b1, 1'b0, 4'd0}, // R3 upper
    '{18'h00055,  6'h07, 18'h00055,  1'b1, 1'b0, 1'b0, 4'd0}, // R3 lower
    '{18'h3FFFF,  6'h0F, 18'd7,      1'b0, 1'b0, 1'b0, 4'd0}, // R4 wrap
    '{18'd10,     6'h10, 18'd100,    1'b0, 1'b0, 1'b0, 4'd1}, // R5
    '{18'd9,      6'h18, 18'd100,    1'b0, 1'b0, 1'b0, 4'd1}, // R5 indexed
    '{18'd10,     6'h39, 18'd102,    1'b0, 1'b0, 1'b0, 4'd1}, // R6
    '{18'd20,     6'h3C, 18'd205,    1'b0, 1'b0, 1'b0, 4'd1}, // R6 replaces X3
    '{18'd12,     6'h31, 18'd116,    1'b0, 1'b0, 1'b0, 4'd2}, // R6 first kept
    '{18'd0,      6'h20, 18'd0,      1'b0, 1'b0, 1'b1, 4'd0}, // R7 tally
    '{18'd0,      6'h13, 18'd0,      1'b0, 1'b0, 1'b1, 4'd0}, // R7
    '{18'd0,      6'h37, 18'd0,      1'b0, 1'b0, 1'b1, 4'd0}, // R7
    '{18'd13,     6'h10, 18'd0,      1'b0, 1'b0, 1'b1, 4'd1}, // R7 via chain
    '{18'd14,     6'h10, 18'd7,      1'b1, 1'b1, 1'b0, 4'd1}, // R3 after fetch
    '{18'd11,     6'h10, 18'd0,      1'b0, 1'b0, 1'b1, 4'd8}, // R8
    '{18'd11,     6'h30, 18'd0,      1'b0, 1'b0, 1'b1, 4'd8}, // R8
    '{18'd14,     6'h30, 18'd7,      1'b0, 1'b0, 1'b0, 4'd1}  // R6 no imm
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [17:0] y, input logic [5:0] tag);
    @(negedge clk);
    ins_y = y; ins_tag = tag; start = 1'b1; fetches = 0;
    @(negedge clk);
    start = 1'b0;
    r_done = 1'b0;
    for (int k = 0; k < 300 && !r_done; k++) begin
      if (done) begin
        r_done = 1'b1; r_ea = ea; r_imm = imm; r_hi = imm_upper; r_flt = fault;
      end else @(negedge clk);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk); #1;
      if (mem_req) begin
        logic [17:0] a;
        a = mem_addr;
        fetches++;
        repeat (2) @(posedge clk);
        #1 mem_valid = 1'b1; mem_data = mem[a[4:0]];
        @(posedge clk);
        #1 mem_valid = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) xr[i*18 +: 18] = 18'(i + 1);
    for (int i = 0; i < 32; i++) mem[i] = '0;
    mem[10] = {18'd100, 12'h0, 6'h00};
    mem[11] = {18'd10,  12'h0, 6'h18};
    mem[12] = {18'd10,  12'h0, 6'h30};
    mem[13] = {18'd5,   12'h0, 6'h20};
    mem[14] = {18'd7,   12'h0, 6'h03};
    mem[20] = {18'd200, 12'h0, 6'h0B};

    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req && !fault, "R1 in reset",
        {busy, done, mem_req, fault}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_req && !fault, "R1 after reset",
        {busy, done, mem_req, fault}, 0);

    for (int v = 0; v < NV; v++) begin
      apply(VEC[v].y, VEC[v].tag);
      chk(r_done && r_flt == VEC[v].flt && r_imm == VEC[v].imm &&
          (VEC[v].flt || (r_ea == VEC[v].ea && r_hi == VEC[v].hi)) &&
          fetches == int'(VEC[v].nf),
          $sformatf("R2-R8 vector %0d (see comment)", v),
          {r_done, r_flt, r_imm, r_hi, r_ea, 8'(fetches)},
          {1'b1, VEC[v].flt, VEC[v].imm, VEC[v].hi, VEC[v].ea, 4'h0, VEC[v].nf});
      @(negedge clk);
      chk(!done, "R9 done is one cycle", 64'(done), 0);
    end

    @(negedge clk);
    ins_y = 18'd10; ins_tag = 6'h10; start = 1'b1; fetches = 0;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    ins_y = 18'd5; ins_tag = 6'h00; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    r_done = 1'b0;
    for (int k = 0; k < 50 && !r_done; k++) begin
      if (done) begin r_done = 1'b1; r_ea = ea; end
      else @(negedge clk);
    end
    chk(r_done && r_ea == 18'd100 && fetches == 1, "R9 start while busy ignored",
        {r_done, r_ea, 8'(fetches)}, {1'b1, 18'd100, 8'd1});
    r_done = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (done || busy) r_done = 1'b1;
    end
    chk(!r_done, "R9 no second walk", 64'(r_done), 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule